// File: doc/BRIEF.md
# Variable Pulse Width Frame Transmitter

This block puts a message onto a single-wire bus using variable pulse width encoding. A stream of bytes comes in through a valid/ready handshake. The block drives one registered output that marks the line active or passive. A frame opens with a long active start symbol. Each data byte follows, most significant bit first. A bit's value is carried by how long the line stays at its current level, and the level flips on every bit. The frame closes with a passive end-of-data period that stretches into end-of-frame. The block can also drive a long active break pulse on request.

All durations are counted in pulses of a 1 µs tick-enable input, so the clock may be any rate above 1 MHz. Arbitration, checksum bytes and response bytes belong to other blocks. A checksum byte is sent as an ordinary data byte.

Top module: `vpw_tx`

## Requirements
- R1: After reset, `bus_active` is 0 (passive), `busy` is 0, `frame_done` is 0 and `s_ready` is 1.
- R2: A byte accepted while idle opens a frame. `bus_active` goes to 1 (active) for exactly 200 ticks, which is the start symbol.
- R3: A data bit sent in the passive level lasts 64 ticks for a 0 and 128 ticks for a 1. A data bit sent in the active level lasts 128 ticks for a 0 and 64 ticks for a 1.
- R4: Bits leave most significant bit first. The first bit of every byte is passive, and the level flips on every bit, so each 8-bit byte ends active.
- R5: After the last data bit, the line goes from active to passive and stays passive for 280 ticks in total: 200 ticks of end-of-data and 80 more of end-of-frame. `frame_done` then pulses high for one clock, in the same clock in which `busy` falls.
- R6: `busy` is high from the first clock of the start symbol until the clock of `frame_done`. Once a byte marked with `s_last` has been accepted, `s_ready` stays low until the frame has finished.
- R7: If a byte not marked last finishes and no next byte is waiting, the frame closes with the normal 280-tick passive ending and `frame_done`.
- R8: A `brk_req` pulse while idle, with no byte queued, drives the line active for 240 ticks. The line then stays passive for 280 ticks with `busy` high. `frame_done` does not pulse.
- R9: `brk_req` has no effect while `busy` is high, and the symbol durations of the running frame are unchanged.
- R10: Durations count tick pulses, not clocks. With one tick every second clock, every data bit and the closing passive period take twice as many clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_us | input | 1 | One-clock enable, once per microsecond |
| s_valid | input | 1 | Byte offered |
| s_ready | output | 1 | Byte can be taken this clock |
| s_data | input | DATA_W | Byte value, MSB sent first |
| s_last | input | 1 | Byte is the last one of the frame |
| brk_req | input | 1 | Request a break pulse (idle only) |
| bus_active | output | 1 | Registered line level, 1 = active |
| busy | output | 1 | Frame or break in progress |
| frame_done | output | 1 | One-clock pulse at end-of-frame |

## Verification
The bench builds the block with its default parameters: an 8-bit byte, 64/128-tick bit pulses, a 200-tick start symbol, a 200+80-tick ending and a 240-tick break. These are the real 10.4 kbps symbol lengths, so every measured run length is compared with the true microsecond value. The tick input is held high for most tests, which makes one clock equal one microsecond and gives exact run lengths from the first start edge. One test ticks every second clock. That test shows that the counters follow the enable and not the clock. Frames of one, two and three bytes use all-zero, all-one and mixed patterns, so every pairing of bit value and line level appears.

// File: rtl/vpw_tx_pkg.sv
// Package: shared types for the variable pulse width transmitter.
// Assumes nothing beyond IEEE 1800-2017 enums.
package vpw_tx_pkg;

    // Sequencer states, from idle through the frame or break phases
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SOF,
        ST_BIT,
        ST_PAD,
        ST_EOD,
        ST_EOF,
        ST_BRK,
        ST_RCV
    } vpw_state_e;

endpackage

// File: rtl/vpw_tx_timer.sv
// Module: symbol duration counter.
// Loads a length in ticks and flags expiry on the tick that ends it.
// Assumes load values are nonzero; a load takes priority over counting.
module vpw_tx_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt;

    // Count down one per tick after each load, resting at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // Expiry is the tick that takes the count from one to zero
    assign expire = tick && (cnt == CNT_W'(1));

    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0)); // R10

endmodule

// File: rtl/vpw_tx_feed.sv
// Module: one-entry byte holding stage with valid/ready handshake.
// Takes bytes only while the sequencer allows it and the frame is not closed.
// Assumes the sequencer pops only when hold_v is set.
module vpw_tx_feed #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    input  logic              allow,
    input  logic              pop,
    input  logic              frame_end,
    output logic              hold_v,
    output logic [DATA_W-1:0] hold_d,
    output logic              hold_last
);

    logic closed;

    // Ready when the slot is empty, the sequencer allows it and no last byte was taken
    assign s_ready = allow && !hold_v && !closed;

    // Capture offered bytes, release them on pop, track the last-byte flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v    <= 1'b0;
            hold_d    <= '0;
            hold_last <= 1'b0;
            closed    <= 1'b0;
        end else begin
            if (s_valid && s_ready) begin
                hold_v    <= 1'b1;
                hold_d    <= s_data;
                hold_last <= s_last;
                if (s_last) begin
                    closed <= 1'b1;
                end
            end else if (pop) begin
                hold_v <= 1'b0;
            end
            if (frame_end) begin
                closed <= 1'b0;
            end
        end
    end

    AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_v && !pop) |=> (hold_v && $stable(hold_d))); // R6

    AST_CLOSE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(closed) |-> $past(s_last)); // R6

endmodule

// File: rtl/vpw_tx_seq.sv
// Module: symbol sequencer for frames and breaks.
// Chooses each symbol's level and length and drives the registered line.
// Assumes the timer expires once per loaded symbol and that DATA_W >= 2.
module vpw_tx_seq
    import vpw_tx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int T_SHORT = 64,
    parameter int T_LONG  = 128,
    parameter int T_SOF   = 200,
    parameter int T_EOD   = 200,
    parameter int T_EOF   = 280,
    parameter int T_BRK   = 240,
    parameter int CNT_W   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              brk_req,
    input  logic              hold_v,
    input  logic [DATA_W-1:0] hold_d,
    input  logic              hold_last,
    input  logic              expire,
    output logic              pop,
    output logic              load,
    output logic [CNT_W-1:0]  load_val,
    output logic              allow,
    output logic              frame_end,
    output logic              bus_active,
    output logic              busy,
    output logic              frame_done
);

    localparam int IDX_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    vpw_state_e        state, st_n;
    logic              bus_q, bus_n;
    logic [DATA_W-1:0] shreg, sh_n;
    logic [IDX_W-1:0]  bit_idx, idx_n;
    logic              last_q, last_n;
    logic              done_q, done_n;

    // Pulse length of a data bit: long when bit value and level differ
    function automatic logic [CNT_W-1:0] sym_len(input logic b, input logic act);
        return (b ^ act) ? CNT_W'(T_LONG) : CNT_W'(T_SHORT);
    endfunction

    // Next-state and symbol selection for the frame and break sequences
    always_comb begin
        st_n     = state;
        bus_n    = bus_q;
        sh_n     = shreg;
        idx_n    = bit_idx;
        last_n   = last_q;
        done_n   = 1'b0;
        pop      = 1'b0;
        load     = 1'b0;
        load_val = '0;
        case (state)
            ST_IDLE: begin
                if (hold_v) begin
                    pop      = 1'b1;
                    sh_n     = hold_d;
                    last_n   = hold_last;
                    st_n     = ST_SOF;
                    bus_n    = 1'b1;
                    load     = 1'b1;
                    load_val = CNT_W'(T_SOF);
                end else if (brk_req) begin
                    st_n     = ST_BRK;
                    bus_n    = 1'b1;
                    load     = 1'b1;
                    load_val = CNT_W'(T_BRK);
                end
            end
            ST_SOF: begin
                if (expire) begin
                    st_n     = ST_BIT;
                    idx_n    = '0;
                    bus_n    = 1'b0;
                    load     = 1'b1;
                    load_val = sym_len(shreg[DATA_W-1], 1'b0);
                end
            end
            ST_BIT: begin
                if (expire) begin
                    if (bit_idx != IDX_LAST) begin
                        idx_n    = bit_idx + IDX_W'(1);
                        sh_n     = {shreg[DATA_W-2:0], 1'b0};
                        bus_n    = !bus_q;
                        load     = 1'b1;
                        load_val = sym_len(shreg[DATA_W-2], !bus_q);
                    end else if (!last_q && hold_v) begin
                        pop      = 1'b1;
                        sh_n     = hold_d;
                        last_n   = hold_last;
                        idx_n    = '0;
                        bus_n    = !bus_q;
                        load     = 1'b1;
                        load_val = sym_len(hold_d[DATA_W-1], !bus_q);
                    end else if (!bus_q) begin
                        st_n     = ST_PAD;
                        bus_n    = 1'b1;
                        load     = 1'b1;
                        load_val = CNT_W'(T_SHORT);
                    end else begin
                        st_n     = ST_EOD;
                        bus_n    = 1'b0;
                        load     = 1'b1;
                        load_val = CNT_W'(T_EOD);
                    end
                end
            end
            ST_PAD: begin
                if (expire) begin
                    st_n     = ST_EOD;
                    bus_n    = 1'b0;
                    load     = 1'b1;
                    load_val = CNT_W'(T_EOD);
                end
            end
            ST_EOD: begin
                if (expire) begin
                    st_n     = ST_EOF;
                    load     = 1'b1;
                    load_val = CNT_W'(T_EOF - T_EOD);
                end
            end
            ST_EOF: begin
                if (expire) begin
                    st_n   = ST_IDLE;
                    done_n = 1'b1;
                end
            end
            ST_BRK: begin
                if (expire) begin
                    st_n     = ST_RCV;
                    bus_n    = 1'b0;
                    load     = 1'b1;
                    load_val = CNT_W'(T_EOF);
                end
            end
            ST_RCV: begin
                if (expire) begin
                    st_n = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // Register state, line level, shift data and the done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bus_q   <= 1'b0;
            shreg   <= '0;
            bit_idx <= '0;
            last_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state   <= st_n;
            bus_q   <= bus_n;
            shreg   <= sh_n;
            bit_idx <= idx_n;
            last_q  <= last_n;
            done_q  <= done_n;
        end
    end

    assign allow      = (state == ST_IDLE) || (state == ST_SOF) || (state == ST_BIT);
    assign frame_end  = (state == ST_EOF) && expire;
    assign bus_active = bus_q;
    assign busy       = (state != ST_IDLE);
    assign frame_done = done_q;

    AST_SOF_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SOF) |-> bus_q); // R2

    AST_BIT_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BIT && $past(state) == ST_BIT && $past(expire)) |-> (bus_q != $past(bus_q))); // R4

    AST_EOD_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EOD && $past(state) != ST_EOD) |-> ($past(bus_q) && !bus_q)); // R5

    AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (state == ST_IDLE && !bus_q && $past(state) == ST_EOF)); // R5

    AST_BREAK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BRK) |-> (bus_q && !frame_done)); // R8

endmodule

// File: rtl/vpw_tx.sv
// Module: variable pulse width transmitter top.
// Joins the byte holding stage, the symbol sequencer and the duration timer.
// Assumes tick_us pulses for one clock per microsecond and DATA_W is even.
module vpw_tx #(
    parameter int DATA_W  = 8,
    parameter int T_SHORT = 64,
    parameter int T_LONG  = 128,
    parameter int T_SOF   = 200,
    parameter int T_EOD   = 200,
    parameter int T_EOF   = 280,
    parameter int T_BRK   = 240
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_us,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    input  logic              brk_req,
    output logic              bus_active,
    output logic              busy,
    output logic              frame_done
);

    localparam int M1    = (T_SHORT > T_LONG) ? T_SHORT : T_LONG;
    localparam int M2    = (M1 > T_SOF) ? M1 : T_SOF;
    localparam int M3    = (M2 > T_EOF) ? M2 : T_EOF;
    localparam int T_MAX = (M3 > T_BRK) ? M3 : T_BRK;
    localparam int CNT_W = $clog2(T_MAX + 1);

    logic              hold_v, hold_last, pop, allow, frame_end;
    logic [DATA_W-1:0] hold_d;
    logic              load, expire;
    logic [CNT_W-1:0]  load_val;

    vpw_tx_feed #(.DATA_W(DATA_W)) u_feed (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_valid   (s_valid),
        .s_ready   (s_ready),
        .s_data    (s_data),
        .s_last    (s_last),
        .allow     (allow),
        .pop       (pop),
        .frame_end (frame_end),
        .hold_v    (hold_v),
        .hold_d    (hold_d),
        .hold_last (hold_last)
    );

    vpw_tx_seq #(
        .DATA_W  (DATA_W),
        .T_SHORT (T_SHORT),
        .T_LONG  (T_LONG),
        .T_SOF   (T_SOF),
        .T_EOD   (T_EOD),
        .T_EOF   (T_EOF),
        .T_BRK   (T_BRK),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .brk_req    (brk_req),
        .hold_v     (hold_v),
        .hold_d     (hold_d),
        .hold_last  (hold_last),
        .expire     (expire),
        .pop        (pop),
        .load       (load),
        .load_val   (load_val),
        .allow      (allow),
        .frame_end  (frame_end),
        .bus_active (bus_active),
        .busy       (busy),
        .frame_done (frame_done)
    );

    vpw_tx_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_us),
        .load     (load),
        .load_val (load_val),
        .expire   (expire)
    );

endmodule

// File: tb/test_vpw_tx.sv
// Bench: directed scenarios for vpw_tx, each task checking its own results.
module test_vpw_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_us = 1'b1;
    logic       s_valid = 1'b0;
    logic       s_ready;
    logic [7:0] s_data = '0;
    logic       s_last = 1'b0;
    logic       brk_req = 1'b0;
    logic       bus_active, busy, frame_done;

    int n_chk = 0;
    int n_bad = 0;
    int tick_div = 1;
    logic [7:0] fb [4];
    int exp_lv [64];
    int exp_len [64];

    always #4 clk = ~clk;

    vpw_tx i_vpw_tx (
        .clk (clk), .rst_n (rst_n), .tick_us (tick_us),
        .s_valid (s_valid), .s_ready (s_ready), .s_data (s_data),
        .s_last (s_last), .brk_req (brk_req),
        .bus_active (bus_active), .busy (busy), .frame_done (frame_done)
    );

    // Tick generator: every clock, or every second clock
    initial forever begin
        @(negedge clk);
        if (tick_div == 1) tick_us = 1'b1;
        else tick_us = !tick_us;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Measure one run of constant line level, stopping at frame_done
    task automatic measure(output int lv, output int len);
        lv = int'(bus_active);
        len = 0;
        while (int'(bus_active) == lv && !frame_done) begin
            len++;
            @(negedge clk);
        end
    endtask

    // Send nb bytes from fb and check every symbol length of the frame
    task automatic frame_check(input int nb, input bit trunc, input bit poke_brk, input int scale);
        int n = 0;
        int lv = 0;
        exp_lv[n] = 1; exp_len[n] = 200 * scale; n++;
        for (int i = 0; i < nb; i++) begin
            for (int k = 7; k >= 0; k--) begin
                exp_lv[n] = lv;
                exp_len[n] = ((fb[i][k] ^ lv[0]) ? 128 : 64) * scale;
                n++;
                lv = 1 - lv;
            end
        end
        exp_lv[n] = 0; exp_len[n] = 280 * scale; n++;
        fork
            begin
                for (int i = 0; i < nb; i++) begin
                    @(negedge clk);
                    s_valid = 1'b1;
                    s_data  = fb[i];
                    s_last  = (i == nb - 1) && !trunc;
                    while (!s_ready) @(negedge clk);
                end
                @(negedge clk);
                s_valid = 1'b0;
                s_last  = 1'b0;
            end
            begin
                if (poke_brk) begin
                    @(posedge bus_active);
                    repeat (500) @(negedge clk);
                    brk_req = 1'b1;
                    @(negedge clk);
                    brk_req = 1'b0;
                end
            end
            begin
                int ml, mn;
                while (!bus_active) @(negedge clk);
                for (int j = 0; j < n; j++) begin
                    if (j == n - 1) begin
                        chk(busy == 1'b1, "R6 busy in ending", int'(busy), 1);
                        chk(s_ready == 1'b0, "R6 ready low at end", int'(s_ready), 0);
                    end
                    measure(ml, mn);
                    if (j == 0) begin
                        chk(ml == 1, "R2 start level", ml, 1);
                        if (scale == 1) chk(mn == exp_len[j], "R2 start length", mn, exp_len[j]);
                    end else if (j == n - 1) begin
                        chk(ml == 0, "R5 ending level", ml, 0);
                        chk(mn == exp_len[j], "R5 ending length", mn, exp_len[j]);
                    end else begin
                        chk(ml == exp_lv[j], "R4 bit level", ml, exp_lv[j]);
                        chk(mn == exp_len[j], (scale == 1) ? "R3 bit length" : "R10 bit ticks", mn, exp_len[j]);
                    end
                end
                chk(frame_done == 1'b1, "R5 done pulse", int'(frame_done), 1);
                chk(busy == 1'b0, "R5 busy falls with done", int'(busy), 0);
                @(negedge clk);
                chk(frame_done == 1'b0, "R5 done one clock", int'(frame_done), 0);
                chk(s_ready == 1'b1, "R6 ready after frame", int'(s_ready), 1);
            end
        join
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(bus_active == 1'b0, "R1 bus passive", int'(bus_active), 0);
        chk(busy == 1'b0, "R1 busy low", int'(busy), 0);
        chk(frame_done == 1'b0, "R1 done low", int'(frame_done), 0);
        chk(s_ready == 1'b1, "R1 ready high", int'(s_ready), 1);
    endtask

    task automatic t_break();
        int ml, mn;
        int done_seen = 0;
        int rc = 0;
        @(negedge clk);
        brk_req = 1'b1;
        @(negedge clk);
        brk_req = 1'b0;
        measure(ml, mn);
        chk(ml == 1, "R8 break level", ml, 1);
        chk(mn == 240, "R8 break length", mn, 240);
        while (busy) begin
            if (bus_active) done_seen++;
            if (frame_done) done_seen++;
            rc++;
            @(negedge clk);
        end
        chk(rc == 280, "R8 passive recovery", rc, 280);
        chk(done_seen == 0, "R8 no done or active in recovery", done_seen, 0);
        chk(s_ready == 1'b1, "R8 idle after break", int'(s_ready), 1);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        fb[0] = 8'hA5;
        frame_check(1, 1'b0, 1'b0, 1);
        fb[0] = 8'h00; fb[1] = 8'hFF;
        frame_check(2, 1'b0, 1'b0, 1);
        fb[0] = 8'h3C; fb[1] = 8'hC3; fb[2] = 8'h81;
        frame_check(3, 1'b0, 1'b1, 1);   // R9: break request during the frame
        fb[0] = 8'h5A;
        frame_check(1, 1'b1, 1'b0, 1);   // R7: byte not marked last, none follows
        t_break();
        tick_div = 2;
        fb[0] = 8'h96;
        frame_check(1, 1'b0, 1'b0, 2);   // R10: one tick every second clock
        tick_div = 1;
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule